// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog with a small 16-bit register bank on a single-cycle write and combinational read port. The counter loses one count per tick. A tick is either a one-cycle pulse on an input pin or, by parameter, a strobe from an internal prescaler. One tick is meant to stand for 0.6 s of real time. Software keeps the system alive by writing the reload register, which puts the counter back to the programmed start value.

When the counter runs out the first time, a sticky first-timeout flag is set and the count starts over from the start value. The flag can drive a level interrupt. If the counter runs out again while that flag is still set, the block records a second-timeout event and sends out a one-clock reset request, unless the no-reboot gate is set. After this second event the counter stays at zero until the next reload write. Status bits are cleared by writing ones to them, so a keep-alive that also clears the flag means two full countdowns are needed again before a reset.

Top module: `wdt_twostage`

## Requirements
- R1: After reset the counter is halted (0x08 reads 0x0800), every status flag reads 0, the no-reboot gate is set (0x0C reads 0x0020), the interrupt enable is clear (0x10 reads 0), the start value is 4 (0x12 reads 0x0004), the count (0x00) reads 4, and irq and rst_req are low.
- R2: While the counter runs, each tick lowers the count by one. A read of 0x00 returns the count in bits 9:0. Any write to 0x00, whatever its data, loads the start value into the counter.
- R3: While bit 11 of 0x08 is 1, ticks leave the count unchanged. Writing 0 to that bit lets the counter run.
- R4: A write to 0x12 replaces only the start value in bits 9:0, and bits 15:10 always read 0. A write whose bits 9:0 are below 4 is ignored and the previous start value stays.
- R5: A tick that finds the count at 0 while the first-timeout flag (0x04 bit 3) is clear sets that flag and loads the start value into the counter.
- R6: irq is high exactly while the first-timeout flag is set and the enable (0x10 bit 13) is 1.
- R7: A tick that finds the count at 0 while the first-timeout flag is set sets the second-timeout bit (0x06 bit 1). With the no-reboot gate clear, it raises rst_req for exactly one clock, in the same cycle in which the status bit appears. The count then stays at 0 through further ticks until a write to 0x00.
- R8: With the no-reboot gate (0x0C bit 5) set, a second expiry does not raise rst_req. It still sets the second-timeout bit and also sets the boot-status bit (0x06 bit 2).
- R9: The bits at 0x04 bit 3 and 0x06 bits 1 and 2 are cleared by writing 1 to them, and writing 0 leaves them unchanged. After a reload with the flag cleared, one expiry sets only the flag and does not request a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle tick strobe (external tick variant) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the 16-bit register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | First-timeout interrupt, level |
| rst_req | output | 1 | System reset request, one-clock pulse |

## Verification
The assertions assume that reg_wr and tick_in are clean levels sampled at the clock edge. They also assume the start value never drops below 4, which the register bank itself enforces, so a reload always lands on a nonzero count. The stimulus changes every input only on the falling clock edge. It holds each tick for exactly one cycle and issues register writes one at a time, so a tick and a reload never meet except where the reload priority is the point of the check.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_COUNT = 5'h00;
  localparam logic [ADDR_W-1:0] A_STS1  = 5'h04;
  localparam logic [ADDR_W-1:0] A_STS2  = 5'h06;
  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h08;
  localparam logic [ADDR_W-1:0] A_CFG   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_IEN   = 5'h10;
  localparam logic [ADDR_W-1:0] A_START = 5'h12;

  localparam int B_FIRST  = 3;
  localparam int B_SECOND = 1;
  localparam int B_BOOT   = 2;
  localparam int B_HALT   = 11;
  localparam int B_NOBOOT = 5;
  localparam int B_IEN    = 13;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter bit USE_EXT_TICK = 1'b1,
  parameter int PRESCALE     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick
);
  generate
    if (USE_EXT_TICK) begin : g_ext
      assign tick = tick_in;
    end else begin : g_pre
      localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
      logic [PW-1:0] pre_q;
      logic          unused_tick_in;
      assign unused_tick_in = tick_in;
      always_ff @(posedge clk) begin
        if (!rst_n)                                  pre_q <= '0;
        else if (pre_q == PW'(PRESCALE - 1))         pre_q <= '0;
        else                                         pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(PRESCALE - 1));
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             reload,
  input  logic             first_flag,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] count,
  output logic             expire1,
  output logic             expire2
);
  logic held_q;
  logic step;
  logic at_zero;

  assign step    = tick && !halt && !held_q && !reload;
  assign at_zero = (count == '0);
  assign expire1 = step && at_zero && !first_flag;
  assign expire2 = step && at_zero && first_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= CNT_W'(4);
      held_q <= 1'b0;
    end else if (reload) begin
      count  <= start_val;
      held_q <= 1'b0;
    end else if (expire1) begin
      count  <= start_val;
    end else if (expire2) begin
      held_q <= 1'b1;
    end else if (step) begin
      count  <= count - 1'b1;
    end
  end

  assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload) |=> $stable(count));
  assert_reload_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (count == $past(start_val)));
  assert_first_reloads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire1 |=> (count == $past(start_val)));
  assert_held_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !reload) |=> ($stable(count) && count == '0));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire1,
  input  logic              expire2,
  output logic              reload,
  output logic              halt,
  output logic              first_flag,
  output logic [CNT_W-1:0]  start_val,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [CNT_W-1:0] MIN_START = CNT_W'(4);

  logic sec_q, boot_q, noboot_q, ien_q;
  logic wr_sts1, wr_sts2, wr_ctrl, wr_cfg, wr_ien, wr_start;

  assign reload   = reg_wr && (reg_addr == A_COUNT);
  assign wr_sts1  = reg_wr && (reg_addr == A_STS1);
  assign wr_sts2  = reg_wr && (reg_addr == A_STS2);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_cfg   = reg_wr && (reg_addr == A_CFG);
  assign wr_ien   = reg_wr && (reg_addr == A_IEN);
  assign wr_start = reg_wr && (reg_addr == A_START) &&
                    (reg_wdata[CNT_W-1:0] >= MIN_START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt       <= 1'b1;
      first_flag <= 1'b0;
      sec_q      <= 1'b0;
      boot_q     <= 1'b0;
      noboot_q   <= 1'b1;
      ien_q      <= 1'b0;
      start_val  <= MIN_START;
      rst_req    <= 1'b0;
    end else begin
      if (wr_ctrl)  halt      <= reg_wdata[B_HALT];
      if (wr_cfg)   noboot_q  <= reg_wdata[B_NOBOOT];
      if (wr_ien)   ien_q     <= reg_wdata[B_IEN];
      if (wr_start) start_val <= reg_wdata[CNT_W-1:0];

      if (expire1)                          first_flag <= 1'b1;
      else if (wr_sts1 && reg_wdata[B_FIRST]) first_flag <= 1'b0;

      if (expire2)                            sec_q <= 1'b1;
      else if (wr_sts2 && reg_wdata[B_SECOND]) sec_q <= 1'b0;

      if (expire2 && noboot_q)               boot_q <= 1'b1;
      else if (wr_sts2 && reg_wdata[B_BOOT])  boot_q <= 1'b0;

      rst_req <= expire2 && !noboot_q;
    end
  end

  assign irq = first_flag && ien_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_COUNT: reg_rdata[CNT_W-1:0] = count;
      A_STS1:  reg_rdata[B_FIRST]   = first_flag;
      A_STS2: begin
        reg_rdata[B_SECOND] = sec_q;
        reg_rdata[B_BOOT]   = boot_q;
      end
      A_CTRL:  reg_rdata[B_HALT]    = halt;
      A_CFG:   reg_rdata[B_NOBOOT]  = noboot_q;
      A_IEN:   reg_rdata[B_IEN]     = ien_q;
      A_START: reg_rdata[CNT_W-1:0] = start_val;
      default: reg_rdata = '0;
    endcase
  end

  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_rst_with_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> sec_q);
  assert_noboot_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(noboot_q));
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_flag) |-> $past(expire1));
  assert_start_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_val >= MIN_START);
endmodule

// File: rtl/wdt_twostage.sv
module wdt_twostage
  import wdt_pkg::*;
#(
  parameter int CNT_W        = 10,
  parameter bit USE_EXT_TICK = 1'b1,
  parameter int PRESCALE     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic             tick, reload, halt, first_flag, expire1, expire2;
  logic [CNT_W-1:0] count, start_val;

  wdt_tick_gen #(.USE_EXT_TICK(USE_EXT_TICK), .PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .reload(reload),
    .first_flag(first_flag), .start_val(start_val), .count(count),
    .expire1(expire1), .expire2(expire2)
  );

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count),
    .expire1(expire1), .expire2(expire2), .reload(reload), .halt(halt),
    .first_flag(first_flag), .start_val(start_val), .irq(irq),
    .rst_req(rst_req)
  );
endmodule

// File: tb/tb_wdt_twostage.sv
`timescale 1ns/100ps
module tb_wdt_twostage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, rst_req;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  wdt_twostage dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  // {write data, expected start-value readback}
  localparam logic [31:0] START_VEC [8] = '{
    {16'h0002, 16'h0004}, {16'h0010, 16'h0010}, {16'hFC08, 16'h0008},
    {16'h0000, 16'h0008}, {16'h03FF, 16'h03FF}, {16'h0404, 16'h0004},
    {16'h0003, 16'h0004}, {16'h0006, 16'h0006}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(5'h08, v); chk("R1 ctrl", v, 16'h0800);
    rd(5'h0C, v); chk("R1 cfg", v, 16'h0020);
    rd(5'h10, v); chk("R1 ien", v, 16'h0000);
    rd(5'h12, v); chk("R1 start", v, 16'h0004);
    rd(5'h00, v); chk("R1 count", v, 16'h0004);
    rd(5'h04, v); chk("R1 sts1", v, 16'h0000);
    rd(5'h06, v); chk("R1 sts2", v, 16'h0000);
    chk("R1 irq/rst", {14'd0, irq, rst_req}, 16'h0000);
    // R3 halted
    ticks(3);
    rd(5'h00, v); chk("R3 halted count", v, 16'h0004);
    // R2 run and reload
    wr(5'h08, 16'h0000);
    ticks(2);
    rd(5'h00, v); chk("R2 decrement", v, 16'h0002);
    wr(5'h00, 16'hBEEF);
    rd(5'h00, v); chk("R2 reload", v, 16'h0004);
    // R4 table walk
    foreach (START_VEC[i]) begin
      wr(5'h12, START_VEC[i][31:16]);
      rd(5'h12, v); chk("R4 start write", v, START_VEC[i][15:0]);
    end
    // R5 first expiry, start = 6
    wr(5'h00, 16'h0000);
    ticks(6);
    rd(5'h00, v); chk("R5 count at zero", v, 16'h0000);
    rd(5'h04, v); chk("R5 flag not yet", v, 16'h0000);
    ticks(1);
    rd(5'h04, v); chk("R5 flag set", v, 16'h0008);
    rd(5'h00, v); chk("R5 reloaded", v, 16'h0006);
    chk("R6 irq gated off", {15'd0, irq}, 16'h0000);
    wr(5'h10, 16'h2000);
    chk("R6 irq on", {15'd0, irq}, 16'h0001);
    // R9 W1C
    wr(5'h04, 16'h0000);
    rd(5'h04, v); chk("R9 write 0 keeps", v, 16'h0008);
    wr(5'h04, 16'h0008);
    rd(5'h04, v); chk("R9 w1c flag", v, 16'h0000);
    chk("R6 irq off", {15'd0, irq}, 16'h0000);
    // R8 second expiry with no-reboot set
    ticks(7);
    chk("R6 irq again", {15'd0, irq}, 16'h0001);
    ticks(7);
    chk("R8 no rst", {15'd0, rst_req}, 16'h0000);
    rd(5'h06, v); chk("R8 sts2", v, 16'h0006);
    ticks(3);
    rd(5'h00, v); chk("R7 held at zero", v, 16'h0000);
    wr(5'h06, 16'h0006);
    rd(5'h06, v); chk("R9 w1c sts2", v, 16'h0000);
    // R7 reset request pulse
    wr(5'h0C, 16'h0000);
    wr(5'h00, 16'h0000);
    rd(5'h00, v); chk("R7 reload after hold", v, 16'h0006);
    ticks(6);
    chk("R7 no early rst", {15'd0, rst_req}, 16'h0000);
    ticks(1);
    chk("R7 rst high", {15'd0, rst_req}, 16'h0001);
    rd(5'h06, v); chk("R7 sts2 same cycle", v, 16'h0002);
    @(negedge clk);
    chk("R7 rst one cycle", {15'd0, rst_req}, 16'h0000);
    rd(5'h00, v); chk("R7 no reload", v, 16'h0000);
    // R9 keep-alive restores two countdowns
    wr(5'h04, 16'h0008);
    wr(5'h00, 16'h0000);
    ticks(7);
    chk("R9 single expiry no rst", {15'd0, rst_req}, 16'h0000);
    rd(5'h04, v); chk("R9 flag after one", v, 16'h0008);
    rd(5'h00, v); chk("R9 count reloaded", v, 16'h0006);
    // R3 halt mid-run
    ticks(2);
    wr(5'h08, 16'h0800);
    ticks(5);
    rd(5'h00, v); chk("R3 halt mid-run", v, 16'h0004);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule